// File: doc/BRIEF.md
# Shared Interrupt Pin Router

This block takes a vector of shared interrupts that a source block has already masked and latched, and steers each one onto the interrupt request pins of one or more processor contexts. Every interrupt owns two write-only configuration words on a small register bus. The first is a pin-map word: an enable flag plus the number of the request pin to drive. The second is a context-map word: a bit vector in which bit c selects processor context c.

For every context and every request pin, the block ORs together all pending interrupts that are enabled, point at that pin and have that context's bit set. The result goes to a registered request array with one bit per (context, pin) pair. The block also reports its size as two constant codes: the context count minus one, and the interrupt count divided by eight, minus one. Software can size its driver from these codes. Priority selection, vector generation and per-context private interrupts belong to other blocks.

Top module: `irq_pin_router`

## Requirements
- R1: After reset every request output is 0, every pin-map enable flag is clear, and every interrupt's context map selects context 0 only (value 1).
- R2: A bus write with bus_addr[IDX_W] = 0 and index bus_addr[IDX_W-1:0] below N loads that interrupt's pin map: bus_wdata[31] is the enable flag and bus_wdata[PIN_W-1:0] is the pin number.
- R3: An interrupt whose pin-map enable flag is clear drives no request output, whatever its pin number and context map.
- R4: A bus write with bus_addr[IDX_W] = 1 and index below N replaces that interrupt's context map with bus_wdata[P-1:0]. Bit c set routes the interrupt to context c.
- R5: An interrupt whose context map has several bits set drives its pin on every selected context. A context map of zero drives nothing.
- R6: Request bit c*K+k (context c, pin k) is the OR of all pending, enabled interrupts with pin number k and context bit c set. Several sources on one pin merge.
- R7: Request outputs are registered. A change of pend_i that is present at a rising clock edge appears on req_o right after that edge. A configuration write takes effect at the edge after the one that stores it.
- R8: An enabled interrupt whose pin number is K or greater drives no request output.
- R9: A bus write whose index is N or greater changes no configuration.
- R10: ctx_count_code_o equals P-1 and src_count_code_o equals N/8-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | IDX_W+1 | Bit IDX_W selects the word type (0 pin map, 1 context map); low bits give the interrupt index |
| bus_wdata | input | 32 | Write data |
| pend_i | input | N | Masked pending interrupts |
| req_o | output | P*K | Request pins; bit c*K+k is pin k of context c |
| ctx_count_code_o | output | 8 | Context count minus one |
| src_count_code_o | output | 8 | Interrupt count divided by eight, minus one |

## Verification
The hardest case to reach from the ports is a merge: several interrupts that land on the same request pin while other interrupts, with overlapping context maps, land on neighbouring pins of the same contexts. A wrong index in the flattened output would then show up only as a displaced bit. The directed tests build such overlaps on purpose. A pseudo-random sweep then rewrites pin and context maps, including pin numbers beyond the last pin and zero context maps, and compares every request bit against a model kept from the writes alone. Disabled and out-of-range entries are left pending on purpose, so a leak would show on the outputs.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int BUS_W      = 32;
    localparam int MAP_EN_BIT = 31;

    typedef enum logic {
        REG_PINMAP = 1'b0,
        REG_CTXMAP = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/irq_map_regs.sv
module irq_map_regs
    import irq_router_pkg::*;
#(
    parameter int N     = 24,
    parameter int P     = 4,
    parameter int PIN_W = 3,
    parameter int IDX_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [IDX_W:0]       bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [N-1:0]         pm_en_o,
    output logic [N*PIN_W-1:0]   pm_pin_o,
    output logic [N*P-1:0]       ctx_o
);

    logic [IDX_W-1:0] wr_idx;
    reg_sel_e         wr_sel;
    logic             wr_ok;

    assign wr_idx = bus_addr[IDX_W-1:0];
    assign wr_sel = reg_sel_e'(bus_addr[IDX_W]);
    assign wr_ok  = bus_wr && (int'(wr_idx) < N);

    for (genvar i = 0; i < N; i++) begin : g_src
        logic hit;
        assign hit = wr_ok && (int'(wr_idx) == i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pm_en_o[i]                  <= 1'b0;
                pm_pin_o[i*PIN_W +: PIN_W]  <= '0;
                ctx_o[i*P +: P]             <= P'(1);
            end else if (hit) begin
                unique case (wr_sel)
                    REG_PINMAP: begin
                        pm_en_o[i]                 <= bus_wdata[MAP_EN_BIT];
                        pm_pin_o[i*PIN_W +: PIN_W] <= bus_wdata[PIN_W-1:0];
                    end
                    REG_CTXMAP: begin
                        ctx_o[i*P +: P] <= bus_wdata[P-1:0];
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_pin_decode.sv
module irq_pin_decode #(
    parameter int N     = 24,
    parameter int K     = 6,
    parameter int PIN_W = 3
) (
    input  logic [N-1:0]       pm_en_i,
    input  logic [N*PIN_W-1:0] pm_pin_i,
    output logic [N*K-1:0]     sel_o
);

    for (genvar i = 0; i < N; i++) begin : g_src
        logic [PIN_W-1:0] pin;
        assign pin = pm_pin_i[i*PIN_W +: PIN_W];
        for (genvar k = 0; k < K; k++) begin : g_pin
            assign sel_o[i*K+k] = pm_en_i[i] && (pin == PIN_W'(k));
        end
    end

endmodule

// File: rtl/irq_ctx_reduce.sv
module irq_ctx_reduce #(
    parameter int N = 24,
    parameter int P = 4,
    parameter int K = 6
) (
    input  logic [N-1:0]   pend_i,
    input  logic [N*K-1:0] sel_i,
    input  logic [N*P-1:0] ctx_i,
    output logic [P*K-1:0] req_o
);

    for (genvar c = 0; c < P; c++) begin : g_ctx
        for (genvar k = 0; k < K; k++) begin : g_pin
            always_comb begin
                logic acc;
                acc = 1'b0;
                for (int i = 0; i < N; i++) begin
                    acc = acc | (pend_i[i] & sel_i[i*K+k] & ctx_i[i*P+c]);
                end
                req_o[c*K+k] = acc;
            end
        end
    end

endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
    import irq_router_pkg::*;
#(
    parameter int N = 24,
    parameter int P = 4,
    parameter int K = 6,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int PIN_W = (K > 1) ? $clog2(K) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [IDX_W:0]     bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  logic [N-1:0]       pend_i,
    output logic [P*K-1:0]     req_o,
    output logic [7:0]         ctx_count_code_o,
    output logic [7:0]         src_count_code_o
);

    logic [N-1:0]       w_pm_en;
    logic [N*PIN_W-1:0] w_pm_pin;
    logic [N*P-1:0]     w_ctx;
    logic [N*K-1:0]     w_sel;
    logic [P*K-1:0]     w_req_next;

    irq_map_regs #(.N(N), .P(P), .PIN_W(PIN_W), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pm_en_o   (w_pm_en),
        .pm_pin_o  (w_pm_pin),
        .ctx_o     (w_ctx)
    );

    irq_pin_decode #(.N(N), .K(K), .PIN_W(PIN_W)) u_decode (
        .pm_en_i  (w_pm_en),
        .pm_pin_i (w_pm_pin),
        .sel_o    (w_sel)
    );

    irq_ctx_reduce #(.N(N), .P(P), .K(K)) u_reduce (
        .pend_i (pend_i),
        .sel_i  (w_sel),
        .ctx_i  (w_ctx),
        .req_o  (w_req_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_o <= '0;
        else        req_o <= w_req_next;
    end

    assign ctx_count_code_o = 8'(P - 1);
    assign src_count_code_o = 8'(N / 8 - 1);

endmodule

// File: rtl/irq_pin_router_chk.sv
module irq_pin_router_chk #(
    parameter int N     = 24,
    parameter int P     = 4,
    parameter int K     = 6,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [IDX_W:0]   bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [N-1:0]     pend_i,
    input logic [P*K-1:0]   req_o,
    input logic [N-1:0]     pm_en,
    input logic [N*P-1:0]   ctx_flat
);

    logic [IDX_W-1:0] a_idx;
    logic             a_in_range;
    assign a_idx      = bus_addr[IDX_W-1:0];
    assign a_in_range = int'(a_idx) < N;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (req_o == '0)); // R1

    AST_REQ_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_o) |-> $past(|pend_i)); // R7

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_o) |-> $past(|pm_en)); // R3

    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !a_in_range) |=> ($stable(pm_en) && $stable(ctx_flat))); // R9

    AST_CTX_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && a_in_range && bus_addr[IDX_W])
        |=> (ctx_flat[$past(a_idx)*P +: P] == $past(bus_wdata[P-1:0]))); // R4

    AST_PIN_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && a_in_range && !bus_addr[IDX_W])
        |=> (pm_en[$past(a_idx)] == $past(bus_wdata[31]))); // R2

    for (genvar c = 0; c < P; c++) begin : g_ctx
        logic any_sel;
        always_comb begin
            any_sel = 1'b0;
            for (int i = 0; i < N; i++) any_sel = any_sel | ctx_flat[i*P+c];
        end
        AST_CTX_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
            (|req_o[c*K +: K]) |-> $past(any_sel)); // R5
    end

endmodule

bind irq_pin_router irq_pin_router_chk #(.N(N), .P(P), .K(K), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend_i    (pend_i),
    .req_o     (req_o),
    .pm_en     (w_pm_en),
    .ctx_flat  (w_ctx)
);

// File: tb/irq_pin_router_tb.sv
`timescale 1ns/1ps
module irq_pin_router_tb;

    localparam int N     = 24;
    localparam int P     = 4;
    localparam int K     = 6;
    localparam int IDX_W = 5;
    localparam int PIN_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [IDX_W:0]   bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [N-1:0]     pend = '0;
    logic [P*K-1:0]   req;
    logic [7:0]       ctx_code, src_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic             m_en  [N];
    logic [PIN_W-1:0] m_pin [N];
    logic [P-1:0]     m_ctx [N];

    always #2 clk = ~clk;

    irq_pin_router #(.N(N), .P(P), .K(K)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus_wr           (bus_wr),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .pend_i           (pend),
        .req_o            (req),
        .ctx_count_code_o (ctx_code),
        .src_count_code_o (src_code)
    );

    function automatic logic [P*K-1:0] model(input logic [N-1:0] p);
        logic [P*K-1:0] r = '0;
        for (int i = 0; i < N; i++)
            if (p[i] && m_en[i] && int'(m_pin[i]) < K)
                for (int c = 0; c < P; c++)
                    if (m_ctx[i][c]) r[c*K + int'(m_pin[i])] = 1'b1;
        return r;
    endfunction

    task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit ctx_sel, input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = {ctx_sel, IDX_W'(idx)};
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (idx < N) begin
            if (!ctx_sel) begin
                m_en[idx]  = d[31];
                m_pin[idx] = d[PIN_W-1:0];
            end else m_ctx[idx] = d[P-1:0];
        end
    endtask

    task automatic pinmap(input int idx, input bit en, input int pin);
        wr(1'b0, idx, {en, 28'd0, 3'(pin)});
    endtask

    task automatic apply(input logic [N-1:0] p);
        @(negedge clk);
        pend = p;
        @(negedge clk);
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) begin
            pinmap(i, 1'b0, 0);
            wr(1'b1, i, 32'd1);
        end
        apply('0);
    endtask

    task automatic t_reset();
        cmp(32'(req), 32'd0, "R1 reset outputs");
        apply('1);
        cmp(32'(req), 32'd0, "R1 all disabled after reset");
        apply('0);
        pinmap(5, 1'b1, 1);
        apply(N'(1) << 5);
        cmp(32'(req), 32'h2, "R1 default context 0");
        apply('0);
    endtask

    task automatic t_pinmap();
        pinmap(3, 1'b1, 2);
        apply(N'(1) << 3);
        cmp(32'(req), 32'h4, "R2 pin 2 of context 0");
        pinmap(3, 1'b1, 5);
        apply(N'(1) << 3);
        cmp(32'(req), 32'h20, "R2 remap to pin 5");
        clear_all();
    endtask

    task automatic t_disabled();
        wr(1'b0, 7, {1'b0, 28'd0, 3'd4});
        wr(1'b1, 7, 32'hF);
        apply(N'(1) << 7);
        cmp(32'(req), 32'd0, "R3 disabled source quiet");
        clear_all();
    endtask

    task automatic t_ctx();
        pinmap(10, 1'b1, 3);
        wr(1'b1, 10, 32'h4);
        apply(N'(1) << 10);
        cmp(32'(req), 32'(1) << (2*K+3), "R4 context 2 pin 3");
        wr(1'b1, 10, 32'hA);
        apply(N'(1) << 10);
        cmp(32'(req), (32'(1) << (1*K+3)) | (32'(1) << (3*K+3)), "R5 contexts 1 and 3");
        wr(1'b1, 10, 32'h0);
        apply(N'(1) << 10);
        cmp(32'(req), 32'd0, "R5 empty context map");
        clear_all();
    endtask

    task automatic t_merge();
        pinmap(0, 1'b1, 4); wr(1'b1, 0, 32'h2);
        pinmap(23, 1'b1, 4); wr(1'b1, 23, 32'h3);
        pinmap(12, 1'b1, 0); wr(1'b1, 12, 32'h2);
        apply(N'(1) << 0);
        cmp(32'(req), 32'(1) << (K+4), "R6 single source");
        apply((N'(1) << 0) | (N'(1) << 23) | (N'(1) << 12));
        cmp(32'(req), (32'(1) << (K+4)) | (32'(1) << 4) | (32'(1) << K),
            "R6 merged sources");
        apply(N'(1) << 23);
        cmp(32'(req), (32'(1) << (K+4)) | (32'(1) << 4), "R6 other source alone");
        clear_all();
    endtask

    task automatic t_latency();
        pinmap(2, 1'b1, 1);
        @(negedge clk);
        pend = N'(1) << 2;
        #1 cmp(32'(req), 32'd0, "R7 not before edge");
        @(negedge clk);
        cmp(32'(req), 32'h2, "R7 one edge later");
        pend = '0;
        #1 cmp(32'(req), 32'h2, "R7 held until edge");
        @(negedge clk);
        cmp(32'(req), 32'd0, "R7 release one edge later");
        clear_all();
    endtask

    task automatic t_pin_oor();
        pinmap(4, 1'b1, 6);
        pinmap(5, 1'b1, 7);
        apply((N'(1) << 4) | (N'(1) << 5));
        cmp(32'(req), 32'd0, "R8 pin beyond last");
        clear_all();
    endtask

    task automatic t_idx_oor();
        pinmap(9, 1'b1, 2);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = {1'b0, 5'd24}; bus_wdata = {1'b1, 28'd0, 3'd5};
        @(negedge clk);
        bus_addr = {1'b1, 5'd31}; bus_wdata = 32'hF;
        @(negedge clk);
        bus_wr = 1'b0;
        apply('1);
        cmp(32'(req), 32'h4, "R9 out-of-range writes ignored");
        clear_all();
    endtask

    task automatic t_cfg();
        cmp(32'(ctx_code), 32'(P-1), "R10 context count code");
        cmp(32'(src_code), 32'(N/8-1), "R10 source count code");
    endtask

    task automatic t_sweep();
        logic [31:0] lf = 32'hACE1_1234;
        for (int it = 0; it < 20; it++) begin
            for (int j = 0; j < 4; j++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                pinmap(int'(lf[4:0]) % N, lf[9], int'(lf[8:6]));
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                wr(1'b1, int'(lf[12:8]) % N, {28'd0, lf[3:0]});
            end
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            apply(lf[N-1:0]);
            cmp(32'(req), 32'(model(lf[N-1:0])), "R6 sweep against model");
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_en[i] = 1'b0; m_pin[i] = '0; m_ctx[i] = P'(1);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_pinmap();
        t_disabled();
        t_ctx();
        t_merge();
        t_latency();
        t_pin_oor();
        t_idx_oor();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule